// File: doc/BRIEF.md
# Bus-Master DMA Register Front End

This block is the software-visible register file of a two-channel, disk-style bus-master DMA controller. It sits behind a simple I/O slave port with a 4-bit byte offset, separate read and write strobes, an access-size code and 8-bit write data. Each channel owns eight bytes of the 16-byte window. The low four bytes of a channel hold a command byte and a status byte. The high four bytes hold a 32-bit descriptor table pointer.

On the engine side, the block presents each channel's run and direction controls, a one-cycle start pulse and the table pointer. It accepts done, error and interrupt event pulses from the engine and folds them into the status byte. The status byte combines three kinds of bits: plain writable bits, an active flag that only the engine and the command register control, and sticky event bits that software clears by writing a one.

Read data is registered. It appears on `io_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `bmdr_top`

## Requirements
- R1: After a synchronous reset, both channels read back 0 for command, status and pointer, and `eng_run`, `eng_dir`, `eng_start` and `eng_tbl_ptr` are 0.
- R2: A byte read (size code 0) in a channel's control half returns the command byte at offset 0 and the status byte at offset 2. Offsets 1 and 3 return 0xFF. Bits 31:8 of the result are 0.
- R3: A wider read in the control half returns all ones across the access width: 0x0000FFFF for size code 1, and 0xFFFFFFFF for size code 2 or 3.
- R4: A write with a size code other than 0 changes no register.
- R5: A byte write to status (offset 2) has these effects. Bits 6:5 take the written data. Bit 0 keeps its value. Bits 2 and 1 clear where the data holds a 1 and keep their value where it holds a 0. Bits 7, 4 and 3 become 0.
- R6: Byte writes to control offsets 1 and 3 change no register.
- R7: A byte write to offset 0 stores the whole command byte. From the next cycle, `eng_run` follows command bit 0 and `eng_dir` follows command bit 3.
- R8: A command write that takes bit 0 from 0 to 1 raises `eng_start` for exactly one cycle and sets status bit 0. A command write with bit 0 = 0 clears status bit 0. Rewriting bit 0 as 1 while it is already 1 gives no start pulse.
- R9: Byte writes to offsets 4 to 7 load pointer bytes 0 to 3, and pointer bits 1:0 always read 0. A pointer read returns the pointer shifted right by 8 × (offset mod 4) and masked to the access width. `eng_tbl_ptr` carries the pointer.
- R10: An error pulse sets status bit 1, an interrupt pulse sets status bit 2, and a done pulse clears status bit 0. Each takes effect by the next cycle.
- R11: When an event pulse and a register write that would clear the same status bit fall in the same cycle, the event wins.
- R12: Channel n decodes offsets 8n to 8n+7. An access to one channel, or an event on one channel, leaves the other channel's registers unchanged.
- R13: `io_rdata` updates only in the cycle after `io_rd` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Byte offset in the 16-byte window |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_size | input | 2 | Access size: 0 byte, 1 two bytes, 2 or 3 four bytes |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 32 | Registered read data |
| eng_start | output | 2 | Per-channel one-cycle start pulse |
| eng_run | output | 2 | Per-channel command bit 0 |
| eng_dir | output | 2 | Per-channel command bit 3 (transfer direction) |
| eng_tbl_ptr | output | 64 | Channel n's pointer at bits 32n+31:32n |
| ev_done | input | 2 | Per-channel done pulse, clears status bit 0 |
| ev_err | input | 2 | Per-channel error pulse, sets status bit 1 |
| ev_irq | input | 2 | Per-channel interrupt pulse, sets status bit 2 |

## Verification
The register write port and the engine event inputs can act on the same status bit in the same clock cycle. The bench provokes this by holding an event pulse high during a bus write.

Two cases are driven. In the first, a status write with a one in the error position coincides with an error pulse. In the second, a command write that starts the channel coincides with a done pulse. The result is judged by reading the status byte back through the port. The event must win in both cases, and the start pulse must still be seen in the second case.

// File: rtl/bmdr_pkg.sv
package bmdr_pkg;
  localparam int RD_W   = 32;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 32;

  // status byte bit positions
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_RW_L = 5;
  localparam int ST_RW_H = 6;

  // command byte bit positions
  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;

  // control-half byte offsets
  localparam logic [1:0] OFF_CMD = 2'd0;
  localparam logic [1:0] OFF_STS = 2'd2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  function automatic logic [RD_W-1:0] width_ones(input logic [1:0] sz);
    logic [RD_W-1:0] m;
    case (sz)
      SZ_BYTE: m = {{(RD_W-8){1'b0}}, 8'hFF};
      SZ_HALF: m = {{(RD_W-16){1'b0}}, 16'hFFFF};
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bmdr_addr_dec.sv
module bmdr_addr_dec
  import bmdr_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CH_BYTES = 8,
  localparam int ADDR_W  = $clog2(NCH * CH_BYTES),
  localparam int CH_LG   = $clog2(CH_BYTES),
  localparam int SEL_W   = $clog2(NCH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [1:0]        size,
  output logic [SEL_W-1:0]  ch_sel,
  output logic              ptr_half,
  output logic [1:0]        off,
  output logic              byte_acc,
  output logic [NCH-1:0]    cmd_we,
  output logic [NCH-1:0]    sts_we,
  output logic [NCH-1:0]    ptr_we
);
  assign ch_sel   = addr[ADDR_W-1:CH_LG];
  assign ptr_half = addr[2];
  assign off      = addr[1:0];
  assign byte_acc = (size == SZ_BYTE);

  logic wr_byte;
  assign wr_byte = wr && byte_acc;

  for (genvar c = 0; c < NCH; c++) begin : g_strobe
    logic hit;
    assign hit       = wr_byte && (ch_sel == SEL_W'(c));
    assign cmd_we[c] = hit && !ptr_half && (off == OFF_CMD);
    assign sts_we[c] = hit && !ptr_half && (off == OFF_STS);
    assign ptr_we[c] = hit && ptr_half;
  end
endmodule

// File: rtl/bmdr_chan_ctl.sv
module bmdr_chan_ctl
  import bmdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_done,
  input  logic              ev_err,
  input  logic              ev_irq,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] sts_q,
  output logic              start_o,
  output logic              run_o,
  output logic              dir_o
);
  logic [DATA_W-1:0] cmd_d, sts_d;
  logic              start_d;

  always_comb begin
    cmd_d   = cmd_q;
    sts_d   = sts_q;
    start_d = 1'b0;
    if (cmd_we) begin
      cmd_d = wdata;
      if (wdata[CMD_GO] && !cmd_q[CMD_GO]) begin
        start_d       = 1'b1;
        sts_d[ST_ACT] = 1'b1;
      end else if (!wdata[CMD_GO]) begin
        sts_d[ST_ACT] = 1'b0;
      end
    end
    if (sts_we) begin
      sts_d                 = '0;
      sts_d[ST_RW_H:ST_RW_L] = wdata[ST_RW_H:ST_RW_L];
      sts_d[ST_ERR]         = sts_q[ST_ERR] & ~wdata[ST_ERR];
      sts_d[ST_IRQ]         = sts_q[ST_IRQ] & ~wdata[ST_IRQ];
      sts_d[ST_ACT]         = sts_q[ST_ACT];
    end
    // engine events take priority over any register write
    if (ev_err)  sts_d[ST_ERR] = 1'b1;
    if (ev_irq)  sts_d[ST_IRQ] = 1'b1;
    if (ev_done) sts_d[ST_ACT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      sts_q   <= '0;
      start_o <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      sts_q   <= sts_d;
      start_o <= start_d;
    end
  end

  assign run_o = cmd_q[CMD_GO];
  assign dir_o = cmd_q[CMD_DIR];

  p_start_edge_r8: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (cmd_q[CMD_GO] && !$past(cmd_q[CMD_GO])));
  p_err_sets_r10: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> sts_q[ST_ERR]);
  p_irq_sets_r10: assert property (@(posedge clk) disable iff (rst)
    ev_irq |=> sts_q[ST_IRQ]);
  p_done_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> !sts_q[ST_ACT]);
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> $stable(cmd_q));
  p_sts_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_we && !sts_we && !ev_done && !ev_err && !ev_irq) |=> $stable(sts_q));
endmodule

// File: rtl/bmdr_tbl_ptr.sv
module bmdr_tbl_ptr
  import bmdr_pkg::*;
#(
  parameter int W       = PTR_W,
  parameter int ALIGN   = 2,
  localparam int NB     = W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wdata,
  output logic [W-1:0]      q
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] keep_m;
    if (b == 0) begin : g_low
      assign keep_m = {{(8-ALIGN){1'b1}}, {ALIGN{1'b0}}};
    end else begin : g_rest
      assign keep_m = 8'hFF;
    end
    always_ff @(posedge clk) begin
      if (rst)
        q[b*8 +: 8] <= '0;
      else if (we && lane == LANE_W'(b))
        q[b*8 +: 8] <= wdata & keep_m;
    end
  end

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/bmdr_top.sv
module bmdr_top
  import bmdr_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CH_BYTES = 8,
  localparam int ADDR_W  = $clog2(NCH * CH_BYTES),
  localparam int SEL_W   = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [1:0]           io_size,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic [RD_W-1:0]      io_rdata,
  output logic [NCH-1:0]       eng_start,
  output logic [NCH-1:0]       eng_run,
  output logic [NCH-1:0]       eng_dir,
  output logic [NCH*PTR_W-1:0] eng_tbl_ptr,
  input  logic [NCH-1:0]       ev_done,
  input  logic [NCH-1:0]       ev_err,
  input  logic [NCH-1:0]       ev_irq
);
  logic [SEL_W-1:0] ch_sel;
  logic             ptr_half, byte_acc;
  logic [1:0]       off;
  logic [NCH-1:0]   cmd_we, sts_we, ptr_we;

  logic [DATA_W-1:0] cmd_arr [NCH];
  logic [DATA_W-1:0] sts_arr [NCH];
  logic [PTR_W-1:0]  ptr_arr [NCH];

  bmdr_addr_dec #(.NCH(NCH), .CH_BYTES(CH_BYTES)) u_dec (
    .addr(io_addr), .wr(io_wr), .size(io_size),
    .ch_sel(ch_sel), .ptr_half(ptr_half), .off(off), .byte_acc(byte_acc),
    .cmd_we(cmd_we), .sts_we(sts_we), .ptr_we(ptr_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bmdr_chan_ctl u_ctl (
      .clk(clk), .rst(rst),
      .cmd_we(cmd_we[c]), .sts_we(sts_we[c]), .wdata(io_wdata),
      .ev_done(ev_done[c]), .ev_err(ev_err[c]), .ev_irq(ev_irq[c]),
      .cmd_q(cmd_arr[c]), .sts_q(sts_arr[c]),
      .start_o(eng_start[c]), .run_o(eng_run[c]), .dir_o(eng_dir[c])
    );
    bmdr_tbl_ptr #(.W(PTR_W)) u_ptr (
      .clk(clk), .rst(rst),
      .we(ptr_we[c]), .lane(off), .wdata(io_wdata), .q(ptr_arr[c])
    );
    assign eng_tbl_ptr[c*PTR_W +: PTR_W] = ptr_arr[c];

    p_wide_wr_r4: assert property (@(posedge clk) disable iff (rst)
      (io_wr && io_size != SZ_BYTE && ch_sel == SEL_W'(c))
        |=> ($stable(cmd_arr[c]) && $stable(ptr_arr[c])));
  end

  logic [RD_W-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (!ptr_half) begin
      if (!byte_acc)
        rd_d = width_ones(io_size);
      else if (off == OFF_CMD)
        rd_d = RD_W'(cmd_arr[ch_sel]);
      else if (off == OFF_STS)
        rd_d = RD_W'(sts_arr[ch_sel]);
      else
        rd_d = RD_W'(8'hFF);
    end else begin
      rd_d = RD_W'(ptr_arr[ch_sel] >> {off, 3'b000}) & width_ones(io_size);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      io_rdata <= '0;
    else if (io_rd)
      io_rdata <= rd_d;
  end

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/bmdr_top_test.sv
module bmdr_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [1:0]  io_size = '0;
  logic [7:0]  io_wdata = '0;
  logic [31:0] io_rdata;
  logic [1:0]  eng_start, eng_run, eng_dir;
  logic [63:0] eng_tbl_ptr;
  logic [1:0]  ev_done = '0, ev_err = '0, ev_irq = '0;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  bmdr_top uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .eng_start(eng_start), .eng_run(eng_run), .eng_dir(eng_dir),
    .eng_tbl_ptr(eng_tbl_ptr), .ev_done(ev_done), .ev_err(ev_err), .ev_irq(ev_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [1:0] sz, input logic [7:0] d,
                        input logic [1:0] dn, input logic [1:0] er, input logic [1:0] iq);
    @(negedge clk);
    io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
    ev_done = dn; ev_err = er; ev_irq = iq;
    @(negedge clk);
    io_wr = 1'b0; ev_done = '0; ev_err = '0; ev_irq = '0;
  endtask

  task automatic wrb(input logic [3:0] a, input logic [7:0] d);
    bus_wr(a, 2'd0, d, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    io_addr = a; io_size = sz; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic pulse(input logic [1:0] dn, input logic [1:0] er, input logic [1:0] iq);
    @(negedge clk);
    ev_done = dn; ev_err = er; ev_irq = iq;
    @(negedge clk);
    ev_done = '0; ev_err = '0; ev_irq = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(4'h0, 2'd0, v); chk("R1 ch0 cmd", v, 0);
    bus_rd(4'h2, 2'd0, v); chk("R1 ch0 sts", v, 0);
    bus_rd(4'hA, 2'd0, v); chk("R1 ch1 sts", v, 0);
    bus_rd(4'hC, 2'd2, v); chk("R1 ch1 ptr", v, 0);
    chk("R1 engine outputs", {eng_start, eng_run, eng_dir}, 0);
    chk("R1 tbl ptr", eng_tbl_ptr, 0);
    bus_rd(4'h1, 2'd0, v); chk("R2 off1 reads FF", v, 32'hFF);
    bus_rd(4'hB, 2'd0, v); chk("R2 ch1 off3 reads FF", v, 32'hFF);
  endtask

  task automatic t_command;
    logic [31:0] v;
    wrb(4'h0, 8'h09);
    chk("R8 start pulse", eng_start, 2'b01);
    chk("R7 run/dir", {eng_run, eng_dir}, 4'b0101);
    @(negedge clk);
    chk("R8 start one cycle", eng_start, 2'b00);
    bus_rd(4'h0, 2'd0, v); chk("R7 cmd readback", v, 32'h09);
    bus_rd(4'h2, 2'd0, v); chk("R8 active set", v, 32'h01);
    wrb(4'h0, 8'h09);
    chk("R8 no pulse on rewrite", eng_start, 2'b00);
    wrb(4'h0, 8'h08);
    bus_rd(4'h2, 2'd0, v); chk("R8 active cleared", v, 32'h00);
    chk("R7 run low", eng_run, 2'b00);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wrb(4'h8, 8'h01);
    pulse(2'b00, 2'b10, 2'b10);
    bus_rd(4'hA, 2'd0, v); chk("R10 err+irq set", v, 32'h07);
    wrb(4'hA, 8'h00);
    bus_rd(4'hA, 2'd0, v); chk("R5 zero write keeps", v, 32'h07);
    wrb(4'hA, 8'h02);
    bus_rd(4'hA, 2'd0, v); chk("R5 W1C bit1", v, 32'h05);
    wrb(4'hA, 8'hFB);
    bus_rd(4'hA, 2'd0, v); chk("R5 rw bits, rsvd zero", v, 32'h65);
    wrb(4'hA, 8'h9C);
    bus_rd(4'hA, 2'd0, v); chk("R5 W1C bit2, rw cleared", v, 32'h01);
    bus_rd(4'h2, 2'd0, v); chk("R12 ch0 sts untouched", v, 32'h00);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wrb(4'h9, 8'hFF);
    wrb(4'hB, 8'hFF);
    bus_rd(4'h8, 2'd0, v); chk("R6 ch1 cmd kept", v, 32'h01);
    bus_rd(4'hA, 2'd0, v); chk("R6 ch1 sts kept", v, 32'h01);
    bus_wr(4'h0, 2'd1, 8'h01, 2'b00, 2'b00, 2'b00);
    chk("R4 no start on wide write", eng_start, 2'b00);
    bus_wr(4'h0, 2'd2, 8'h01, 2'b00, 2'b00, 2'b00);
    bus_wr(4'hA, 2'd1, 8'h60, 2'b00, 2'b00, 2'b00);
    bus_rd(4'h0, 2'd0, v); chk("R4 ch0 cmd kept", v, 32'h08);
    bus_rd(4'hA, 2'd0, v); chk("R4 ch1 sts kept", v, 32'h01);
  endtask

  task automatic t_wide_read;
    logic [31:0] v;
    bus_rd(4'h0, 2'd1, v); chk("R3 half read", v, 32'h0000FFFF);
    bus_rd(4'h2, 2'd2, v); chk("R3 word read", v, 32'hFFFFFFFF);
    bus_rd(4'h8, 2'd3, v); chk("R3 wide code read", v, 32'hFFFFFFFF);
  endtask

  task automatic t_pointer;
    logic [31:0] v;
    wrb(4'h4, 8'h13); wrb(4'h5, 8'h57); wrb(4'h6, 8'h9B); wrb(4'h7, 8'hDF);
    chk("R9 engine ptr", eng_tbl_ptr, {32'h0, 32'hDF9B5710});
    bus_rd(4'h4, 2'd0, v); chk("R9 low byte aligned", v, 32'h10);
    bus_rd(4'h7, 2'd0, v); chk("R9 top byte", v, 32'hDF);
    bus_rd(4'h6, 2'd1, v); chk("R9 half read", v, 32'hDF9B);
    bus_rd(4'h4, 2'd2, v); chk("R9 word read", v, 32'hDF9B5710);
    bus_wr(4'h4, 2'd2, 8'h00, 2'b00, 2'b00, 2'b00);
    bus_rd(4'h4, 2'd2, v); chk("R4 ptr wide write ignored", v, 32'hDF9B5710);
    bus_rd(4'hC, 2'd2, v); chk("R12 ch1 ptr untouched", v, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    pulse(2'b10, 2'b00, 2'b00);
    bus_rd(4'hA, 2'd0, v); chk("R10 done clears active", v, 32'h00);
    chk("R10 run stays", eng_run, 2'b10);
    bus_rd(4'h2, 2'd0, v); chk("R12 ch0 unaffected", v, 32'h00);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wrb(4'h0, 8'h01);
    pulse(2'b00, 2'b01, 2'b00);
    bus_wr(4'h2, 2'd0, 8'h02, 2'b00, 2'b01, 2'b00);
    bus_rd(4'h2, 2'd0, v); chk("R11 err beats W1C", v, 32'h03);
    bus_wr(4'h2, 2'd0, 8'h06, 2'b00, 2'b00, 2'b01);
    bus_rd(4'h2, 2'd0, v); chk("R11 irq beats W1C", v, 32'h05);
    wrb(4'h0, 8'h00);
    bus_wr(4'h0, 2'd0, 8'h01, 2'b01, 2'b00, 2'b00);
    chk("R11 start still pulses", eng_start, 2'b01);
    bus_rd(4'h2, 2'd0, v); chk("R11 done beats start", v, 32'h04);
    chk("R11 run set", eng_run[0], 1'b1);
  endtask

  task automatic t_rd_hold;
    logic [31:0] v;
    bus_rd(4'h1, 2'd0, v);
    wrb(4'h0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R13 rdata held", io_rdata, 32'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_command;
    t_status;
    t_ignored;
    t_wide_read;
    t_pointer;
    t_events;
    t_collide;
    t_rd_hold;
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule